// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Loader

This block sits between an 8-bit parallel bus and a pair of 12-bit converters. Each channel keeps a staging pair of registers, an 8-bit low part and a 4-bit high part, and a 12-bit output register that feeds the converter. Software fills the staging registers one bus write at a time. It then pulses a shared update strobe so that both converters change on the same clock edge.

Four active-low strobes drive the bus side: select, write, update and clear. A system clock samples them. A write is committed on the clock edge at which the write strobe is first seen high again after a low cycle with select low. The address and data used are the values captured during that last low cycle. When update is held low across a write, the new word goes straight through to the output on the same edge.

Top module: `twin_dac_stager`

## Requirements
- R1: While `clr_n` is sampled low on a clock edge, every staging register and both output codes become zero. This wins over any update or write in that cycle. `rst_n` low clears the same state asynchronously.
- R2: A staging register changes only when the low cycle of `wr_n` had `sel_n` low. A write strobe with `sel_n` high changes nothing.
- R3: The address captured during the write picks the target. `adr[1]` selects the channel (0 = A, 1 = B). `adr[0]` selects the part (0 = low byte, 1 = high nibble).
- R4: A low-byte write stores all of `bus_d[7:0]`. A high-nibble write stores only `bus_d[3:0]`, and `bus_d[7:4]` has no effect. A channel's code is {high nibble, low byte}.
- R5: While `upd_n` is high and `clr_n` is high, both output codes hold their value, even when staging registers are written.
- R6: A clock edge with `upd_n` low loads both channels' output codes from their staging registers on the same edge.
- R7: When `upd_n` is low on the edge that commits a write, the output code already carries the newly written value.
- R8: A write commits on the first clock edge at which `wr_n` is high after a cycle in which it was low. The commit uses the address and data sampled at the edge before, so bus changes made together with the release of `wr_n` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d | input | 8 | Parallel data byte |
| adr | input | 2 | Staging-register address |
| sel_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe |
| upd_n | input | 1 | Active-low shared update |
| clr_n | input | 1 | Active-low clear |
| code_a | output | 12 | Output code of channel A |
| code_b | output | 12 | Output code of channel B |

## Verification
The bench sweeps 256 data patterns through all four staging registers. It checks that the outputs stay frozen until an update arrives. A design that leaked staged data early would show the half-written code, or one channel ahead of the other.

On every write, the bench changes address and data together with the release of the write strobe. A design that used the late bus values would write the wrong register or the wrong byte. The bench also writes high nibbles with junk in the upper four bits, issues writes with select high, and clears while update is low. These catch a design that lets the upper bits leak, that ignores select, or that gives the update priority over clear.

// File: rtl/twin_dac_stager.sv
module twin_dac_stager #(
  parameter int LO_W = 8,
  parameter int HI_W = 4,
  localparam int CODE_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LO_W-1:0]   bus_d,
  input  logic [1:0]        adr,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              upd_n,
  input  logic              clr_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);

  logic            wr_q, cs_q;
  logic [1:0]      a_q;
  logic [LO_W-1:0] d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      cs_q <= 1'b1;
      a_q  <= '0;
      d_q  <= '0;
    end else begin
      wr_q <= wr_n;
      cs_q <= sel_n;
      a_q  <= adr;
      d_q  <= bus_d;
    end
  end

  wire commit = !wr_q && wr_n && !cs_q;

  logic [1:0][LO_W-1:0] lo_q, lo_n;
  logic [1:0][HI_W-1:0] hi_q, hi_n;

  always_comb begin
    lo_n = lo_q;
    hi_n = hi_q;
    if (commit) begin
      if (a_q[0]) hi_n[a_q[1]] = d_q[HI_W-1:0];
      else        lo_n[a_q[1]] = d_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      code_a <= '0;
      code_b <= '0;
    end else if (!clr_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      code_a <= '0;
      code_b <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
      if (!upd_n) begin
        code_a <= {hi_n[0], lo_n[0]};
        code_b <= {hi_n[1], lo_n[1]};
      end
    end
  end

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (code_a == '0 && code_b == '0 && lo_q == '0 && hi_q == '0));

  // R2
  no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && clr_n) |=> ($stable(lo_q) && $stable(hi_q)));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_n && clr_n) |=> ($stable(code_a) && $stable(code_b)));

  // R6
  upd_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_n && clr_n) |=> (code_a == {hi_q[0], lo_q[0]} && code_b == {hi_q[1], lo_q[1]}));

  // R8
  late_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && clr_n && a_q == 2'b00) |=> (lo_q[0] == $past(d_q)));

endmodule

// File: tb/twin_dac_stager_tb.sv
module twin_dac_stager_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_d = '0;
  logic [1:0] adr = '0;
  logic sel_n = 1'b1, wr_n = 1'b1, upd_n = 1'b1, clr_n = 1'b1;
  logic [11:0] code_a, code_b;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [7:0] m_lo [2];
  logic [3:0] m_hi [2];
  logic [11:0] m_out [2];

  always #5 clk = ~clk;

  twin_dac_stager u_dut (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .adr(adr), .sel_n(sel_n),
    .wr_n(wr_n), .upd_n(upd_n), .clr_n(clr_n), .code_a(code_a), .code_b(code_b)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    chk(req, code_a, m_out[0]);
    chk(req, code_b, m_out[1]);
  endtask

  // R3 R4 R8: bus is scrambled together with the release of wr_n
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input bit cs_off, input bit with_upd);
    @(negedge clk);
    sel_n = cs_off; wr_n = 1'b0; adr = a; bus_d = d;
    @(negedge clk);
    wr_n = 1'b1; adr = ~a; bus_d = ~d;
    upd_n = with_upd ? 1'b0 : 1'b1;
    @(negedge clk);
    sel_n = 1'b1; upd_n = 1'b1;
    if (!cs_off) begin
      if (a[0]) m_hi[a[1]] = d[3:0];
      else      m_lo[a[1]] = d;
    end
    if (with_upd) begin
      m_out[0] = {m_hi[0], m_lo[0]};
      m_out[1] = {m_hi[1], m_lo[1]};
    end
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd_n = 1'b0;
    @(negedge clk); upd_n = 1'b1;
    m_out[0] = {m_hi[0], m_lo[0]};
    m_out[1] = {m_hi[1], m_lo[1]};
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin m_lo[k] = '0; m_hi[k] = '0; m_out[k] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 async reset", code_a, 12'h000);
    chk("R1 async reset", code_b, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: high-nibble junk bits, R5: outputs hold until update
    bus_write(2'b00, 8'hA5, 1'b0, 1'b0);
    bus_write(2'b01, 8'hF3, 1'b0, 1'b0);
    bus_write(2'b10, 8'h3C, 1'b0, 1'b0);
    bus_write(2'b11, 8'h9E, 1'b0, 1'b0);
    chk("R5 hold before update", code_a, 12'h000);
    chk("R5 hold before update", code_b, 12'h000);
    pulse_upd();
    chk("R6 R4 channel A code", code_a, 12'h3A5);
    chk("R6 R3 channel B code", code_b, 12'hE3C);

    // R2: select high blocks the transfer
    bus_write(2'b00, 8'h11, 1'b1, 1'b0);
    bus_write(2'b11, 8'h07, 1'b1, 1'b0);
    pulse_upd();
    chk("R2 select high ignored", code_a, 12'h3A5);
    chk("R2 select high ignored", code_b, 12'hE3C);

    // R7: write while update held low
    bus_write(2'b10, 8'h42, 1'b0, 1'b1);
    chk("R7 transparent B", code_b, 12'hE42);
    chk("R7 transparent A unchanged", code_a, 12'h3A5);

    // R1: clear wins over update and write
    @(negedge clk);
    sel_n = 1'b0; wr_n = 1'b0; adr = 2'b00; bus_d = 8'hFF;
    @(negedge clk);
    wr_n = 1'b1; upd_n = 1'b0; clr_n = 1'b0;
    @(negedge clk);
    sel_n = 1'b1; upd_n = 1'b1; clr_n = 1'b1;
    for (int k = 0; k < 2; k++) begin m_lo[k] = '0; m_hi[k] = '0; m_out[k] = '0; end
    chk_outs("R1 clear priority");
    pulse_upd();
    chk_outs("R1 staging cleared");

    // R3 R4 R6 sweep over data patterns
    for (int i = 0; i < 256; i++) begin
      bus_write(2'b00, i[7:0], 1'b0, 1'b0);
      bus_write(2'b01, i[7:0], 1'b0, 1'b0);
      bus_write(2'b10, ~i[7:0], 1'b0, 1'b0);
      bus_write(2'b11, {i[3:0], i[7:4]}, 1'b0, (i % 4) == 3);
      if ((i % 4) != 3) chk_outs("R5 sweep hold");
      else begin
        chk("R3 sweep A", code_a, {i[3:0], i[7:0]});
        chk("R3 sweep B", code_b, {i[7:4], ~i[7:0]});
      end
    end
    pulse_upd();
    chk_outs("R6 final update");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule